// File: doc/BRIEF.md
# Head-per-track disk controller datapath

This block sits between a character I/O channel and the storage of a head-per-track disk. It moves 12-bit characters one at a time. Two characters share each 24-bit storage word, so the block packs characters on writes and unpacks them on reads. It keeps the disk address and a byte pointer within the current sector. At the end of a sector it advances the address in one of two modes: a mode that keeps the transfer inside the current track, or a mode that carries into the track number. Each logical unit can be write-protected through a mask. When a write ends part way through a sector, the rest of that sector is cleared to zero.

The host drives a short protocol. First it announces an address load, which also picks the increment mode. It then supplies the address and connects. After that it exchanges characters with the block, and finally it terminates the operation. Rotational timing comes from an external timer as a strobe. The block turns that strobe into a transfer-request level that the channel services. A status query port returns one of three skip conditions. Storage is an internal synchronous RAM of `STORE_WORDS` words, kept as two 12-bit halves.

Top module: `hpt_disk_ctrl`

## Requirements
- R1: After reset the address, byte pointer, increment mode, error flag, busy, transfer request and 12-bit mode output are all zero.
- R2: An address-load alert taken while idle latches `alert_stay` as the increment mode and arms a pending load. `addr_load` then copies `addr_in` into the address and clears the pending load. An alert while busy is refused and sets the error flag, and a following `addr_load` leaves the address unchanged.
- R3: A connect is accepted only when idle with no pending load. It clears the error flag and byte pointer, sets the 12-bit mode output, and raises busy. A refused connect leaves busy low.
- R4: While transferring, a timer strobe raises `xfer_req` one cycle later. Any character strobe or termination drops it. It is always low when not busy.
- R5: The even character (pointer bit 0 = 0) lives in word bits 23:12 and the odd character in bits 11:0. Writing an even character also clears the odd half. Read data appears with `rd_valid` one cycle after the read strobe.
- R6: Each accepted character increments the byte pointer. When it reaches two characters per word times the words per sector, it returns to 0 and the address advances. With the stay mode set, only the sector field (low `SEC_W` bits) increments and wraps within the track.
- R7: With the stay mode clear, the combined track/sector field (low `TRK_W+SEC_W` bits) increments and wraps. The logical-unit field (top `LU_W` bits) changes only by an address load.
- R8: A write to a logical unit whose `wp_mask` bit is set is not stored. It sets the error flag, pulses `chan_err_eor` for one cycle and ends busy.
- R9: A read or write whose word index `address*words_per_sector + pointer/2` is at or beyond `STORE_WORDS` takes the same error path as R8.
- R10: Terminating with `end_write` high and a nonzero pointer P zero-fills words ceil(P/2) to the last word of the sector, one word per cycle, with busy held high. Words before ceil(P/2) are kept.
- R11: `sks_true` is true for `sks_sel` 0 when not busy, for 1 when no error is latched, and for 2 when the current logical unit is not protected. It is always false for 3.
- R12: Terminating a read, or a write with pointer 0, ends busy on the next cycle with no fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conn_req | input | 1 | Connect command strobe |
| alert_addr | input | 1 | Address-load alert strobe |
| alert_stay | input | 1 | Increment mode carried with the alert (1 = stay in track) |
| addr_load | input | 1 | Address value strobe |
| addr_in | input | ADDR_W (15) | New disk address: unit, track, sector from top |
| wp_mask | input | 2**LU_W (8) | Write-protect bit per logical unit |
| timer_tick | input | 1 | Rotational timer strobe |
| xfer_valid | input | 1 | One-cycle character transfer strobe |
| xfer_write | input | 1 | Transfer direction (1 = write) |
| wr_char | input | CHAR_W (12) | Character to write |
| end_req | input | 1 | Terminate the operation |
| end_write | input | 1 | The terminated operation was a write |
| sks_sel | input | 2 | Status query selector |
| sks_true | output | 1 | Status query answer |
| rd_valid | output | 1 | Read character valid |
| rd_char | output | CHAR_W (12) | Read character |
| xfer_req | output | 1 | Transfer request to channel |
| busy | output | 1 | Operation or fill in progress |
| err_flag | output | 1 | Latched error |
| chan_err_eor | output | 1 | One-cycle error plus end-of-record pulse |
| mode12 | output | 1 | 12-bit character mode selected |
| addr_out | output | ADDR_W (15) | Current disk address |
| byte_ptr | output | WPS_LOG2+1 (7) | Character index within the sector |

## Verification
The bound checker watches several properties on every cycle. It checks that the transfer request stays low while idle and falls after each strobe. It checks that every rise of busy comes with a clean error flag and a zero pointer, and that each error pulse finds the block disconnected with the flag latched. It also checks that the logical-unit field never moves without an address load, that a refused alert latches an error, and that read data only follows a read strobe. The bench scenarios are what show data behaviour. Packing order, clearing of the odd half, the exact zero-fill span and timing, both increment modes and wraps at a sector boundary are visible only through read-back and address values after full sectors.

// File: rtl/hpt_disk_pkg.sv
package hpt_disk_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_FILL = 2'd2
   } hpt_state_e;

   localparam logic [1:0] SKS_READY   = 2'd0;
   localparam logic [1:0] SKS_NO_ERR  = 2'd1;
   localparam logic [1:0] SKS_NO_PROT = 2'd2;

endpackage

// File: rtl/hpt_addr_seq.sv
module hpt_addr_seq #(
   parameter int LU_W     = 3,
   parameter int TRK_W    = 6,
   parameter int SEC_W    = 6,
   parameter int WPS_LOG2 = 6,
   localparam int ADDR_W  = LU_W + TRK_W + SEC_W,
   localparam int PTR_W   = WPS_LOG2 + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              mode_en,
   input  logic              mode_val,
   input  logic              ptr_clr,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic [PTR_W-1:0]  ptr,
   output logic              stay
);

   localparam int TS_W = TRK_W + SEC_W;

   logic [PTR_W:0]      ptr_nx;
   logic [SEC_W-1:0]    sec_inc;
   logic [TS_W-1:0]     ts_inc;
   logic [ADDR_W-1:0]   addr_adv;

   assign ptr_nx  = {1'b0, ptr} + 1'b1;
   assign sec_inc = addr[SEC_W-1:0] + 1'b1;
   assign ts_inc  = addr[TS_W-1:0] + 1'b1;

   always_comb begin
      if (stay) addr_adv = {addr[ADDR_W-1:SEC_W], sec_inc};
      else      addr_adv = {addr[ADDR_W-1:TS_W], ts_inc};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr <= '0;
         ptr  <= '0;
         stay <= 1'b0;
      end else begin
         if (mode_en) stay <= mode_val;
         if (load_en) begin
            addr <= load_val;
         end else if (step) begin
            if (ptr_nx[PTR_W]) begin
               ptr  <= '0;
               addr <= addr_adv;
            end else begin
               ptr <= ptr_nx[PTR_W-1:0];
            end
         end
         if (ptr_clr) ptr <= '0;
      end
   end

endmodule

// File: rtl/hpt_half_ram.sv
module hpt_half_ram #(
   parameter int DEPTH = 1024,
   parameter int AW    = 10,
   parameter int W     = 12
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end

endmodule

// File: rtl/hpt_disk_ctrl.sv
module hpt_disk_ctrl
   import hpt_disk_pkg::*;
#(
   parameter int LU_W        = 3,
   parameter int TRK_W       = 6,
   parameter int SEC_W       = 6,
   parameter int WPS_LOG2    = 6,
   parameter int CHAR_W      = 12,
   parameter int STORE_WORDS = 1024,
   localparam int ADDR_W     = LU_W + TRK_W + SEC_W,
   localparam int PTR_W      = WPS_LOG2 + 1,
   localparam int NUM_LU     = 1 << LU_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conn_req,
   input  logic              alert_addr,
   input  logic              alert_stay,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [NUM_LU-1:0] wp_mask,
   input  logic              timer_tick,
   input  logic              xfer_valid,
   input  logic              xfer_write,
   input  logic [CHAR_W-1:0] wr_char,
   input  logic              end_req,
   input  logic              end_write,
   input  logic [1:0]        sks_sel,
   output logic              sks_true,
   output logic              rd_valid,
   output logic [CHAR_W-1:0] rd_char,
   output logic              xfer_req,
   output logic              busy,
   output logic              err_flag,
   output logic              chan_err_eor,
   output logic              mode12,
   output logic [ADDR_W-1:0] addr_out,
   output logic [PTR_W-1:0]  byte_ptr
);

   localparam int LIN_W  = ADDR_W + WPS_LOG2;
   localparam int RAM_AW = (STORE_WORDS > 1) ? $clog2(STORE_WORDS) : 1;
   localparam logic [LIN_W:0] LIMIT = (LIN_W+1)'(STORE_WORDS);

   // elaboration-time parameter checks
   if (LIN_W > 30) begin : g_bad_lin
      $error("hpt_disk_ctrl: address plus word index too wide");
   end
   if (STORE_WORDS < (1 << WPS_LOG2)) begin : g_bad_small
      $error("hpt_disk_ctrl: storage smaller than one sector");
   end
   if (LIN_W <= 30 && STORE_WORDS > (1 << LIN_W)) begin : g_bad_big
      $error("hpt_disk_ctrl: storage larger than the address space");
   end
   if (CHAR_W < 1 || LU_W < 1 || TRK_W < 1 || SEC_W < 1) begin : g_bad_w
      $error("hpt_disk_ctrl: field widths must be positive");
   end

   hpt_state_e st_q;

   logic [ADDR_W-1:0]   addr_q;
   logic [PTR_W-1:0]    ptr_q;
   logic                stay_q;
   logic                pend_q, err_q, req_q, mode12_q;
   logic                rd_pend_q, rd_odd_q, cerr_q;
   logic [WPS_LOG2-1:0] fill_idx_q;

   logic [LU_W-1:0]     cur_lu;
   logic                cur_prot;
   logic [LIN_W-1:0]    xfer_lin, fill_lin, base_lin;
   logic                xfer_in, fill_in, base_in;
   logic                conn_ok, alert_ok, alert_bad, load_ok;
   logic                end_x, acc, bad, good;
   logic [PTR_W:0]      fill_from;
   logic                fill_go, fill_last;

   logic [1:0]              h_we;
   logic [1:0][CHAR_W-1:0]  h_wd;
   logic [1:0][CHAR_W-1:0]  h_rd;
   logic [RAM_AW-1:0]       ram_wa, ram_ra;
   logic                    ram_re;

   assign cur_lu   = addr_q[ADDR_W-1 -: LU_W];
   assign cur_prot = wp_mask[cur_lu];

   assign xfer_lin = {addr_q, ptr_q[PTR_W-1:1]};
   assign fill_lin = {addr_q, fill_idx_q};
   assign base_lin = {addr_q, {WPS_LOG2{1'b0}}};
   assign xfer_in  = ({1'b0, xfer_lin} < LIMIT);
   assign fill_in  = ({1'b0, fill_lin} < LIMIT);
   assign base_in  = ({1'b0, base_lin} < LIMIT);

   assign conn_ok   = conn_req && (st_q == ST_IDLE) && !pend_q;
   assign alert_ok  = alert_addr && (st_q == ST_IDLE);
   assign alert_bad = alert_addr && (st_q != ST_IDLE);
   assign load_ok   = addr_load && pend_q;

   assign end_x = end_req && (st_q == ST_XFER);
   assign acc   = xfer_valid && (st_q == ST_XFER) && !end_req;
   assign bad   = acc && (!xfer_in || (xfer_write && cur_prot));
   assign good  = acc && !bad;

   assign fill_from = ({1'b0, ptr_q} + 1'b1) >> 1;
   assign fill_go   = end_x && end_write && (ptr_q != '0) && base_in &&
                      !fill_from[WPS_LOG2];
   assign fill_last = (fill_idx_q == {WPS_LOG2{1'b1}});

   hpt_addr_seq #(
      .LU_W     (LU_W),
      .TRK_W    (TRK_W),
      .SEC_W    (SEC_W),
      .WPS_LOG2 (WPS_LOG2)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (load_ok),
      .load_val (addr_in),
      .mode_en  (alert_ok),
      .mode_val (alert_stay),
      .ptr_clr  (conn_ok),
      .step     (good),
      .addr     (addr_q),
      .ptr      (ptr_q),
      .stay     (stay_q)
   );

   // storage write/read steering: index 1 = even (upper) half, 0 = odd (lower)
   always_comb begin
      h_we   = 2'b00;
      h_wd   = '0;
      ram_wa = xfer_lin[RAM_AW-1:0];
      if (st_q == ST_FILL) begin
         h_we   = {2{fill_in}};
         ram_wa = fill_lin[RAM_AW-1:0];
      end else if (good && xfer_write) begin
         if (!ptr_q[0]) begin
            h_we    = 2'b11;
            h_wd[1] = wr_char;
         end else begin
            h_we[0] = 1'b1;
            h_wd[0] = wr_char;
         end
      end
   end

   assign ram_re = good && !xfer_write;
   assign ram_ra = xfer_lin[RAM_AW-1:0];

   for (genvar h = 0; h < 2; h++) begin : g_half
      hpt_half_ram #(
         .DEPTH (STORE_WORDS),
         .AW    (RAM_AW),
         .W     (CHAR_W)
      ) u_ram (
         .clk   (clk),
         .we    (h_we[h]),
         .waddr (ram_wa),
         .wdata (h_wd[h]),
         .re    (ram_re),
         .raddr (ram_ra),
         .rdata (h_rd[h])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         pend_q     <= 1'b0;
         err_q      <= 1'b0;
         req_q      <= 1'b0;
         mode12_q   <= 1'b0;
         rd_pend_q  <= 1'b0;
         rd_odd_q   <= 1'b0;
         cerr_q     <= 1'b0;
         fill_idx_q <= '0;
      end else begin
         rd_pend_q <= ram_re;
         if (ram_re) rd_odd_q <= ptr_q[0];
         cerr_q <= bad;

         if (alert_ok)     pend_q <= 1'b1;
         else if (load_ok) pend_q <= 1'b0;

         if (alert_bad || bad) err_q <= 1'b1;
         else if (conn_ok)     err_q <= 1'b0;

         if (conn_ok) mode12_q <= 1'b1;

         case (st_q)
            ST_IDLE: begin
               req_q <= 1'b0;
               if (conn_ok) st_q <= ST_XFER;
            end
            ST_XFER: begin
               if (end_x) begin
                  req_q      <= 1'b0;
                  fill_idx_q <= fill_from[WPS_LOG2-1:0];
                  st_q       <= fill_go ? ST_FILL : ST_IDLE;
               end else if (bad) begin
                  req_q <= 1'b0;
                  st_q  <= ST_IDLE;
               end else if (acc) begin
                  req_q <= 1'b0;
               end else if (timer_tick) begin
                  req_q <= 1'b1;
               end
            end
            ST_FILL: begin
               req_q <= 1'b0;
               if (fill_last) st_q <= ST_IDLE;
               else           fill_idx_q <= fill_idx_q + 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (sks_sel)
         SKS_READY:   sks_true = (st_q == ST_IDLE);
         SKS_NO_ERR:  sks_true = !err_q;
         SKS_NO_PROT: sks_true = !cur_prot;
         default:     sks_true = 1'b0;
      endcase
   end

   assign rd_valid     = rd_pend_q;
   assign rd_char      = rd_odd_q ? h_rd[0] : h_rd[1];
   assign xfer_req     = req_q;
   assign busy         = (st_q != ST_IDLE);
   assign err_flag     = err_q;
   assign chan_err_eor = cerr_q;
   assign mode12       = mode12_q;
   assign addr_out     = addr_q;
   assign byte_ptr     = ptr_q;

endmodule

// File: rtl/hpt_disk_ctrl_chk.sv
module hpt_disk_ctrl_chk #(
   parameter int LU_W   = 3,
   parameter int ADDR_W = 15,
   parameter int PTR_W  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              alert_addr,
   input logic              addr_load,
   input logic              xfer_valid,
   input logic              xfer_write,
   input logic              busy,
   input logic              xfer_req,
   input logic              err_flag,
   input logic              chan_err_eor,
   input logic              mode12,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] addr_out,
   input logic [PTR_W-1:0]  byte_ptr
);

   assert_idle_no_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !xfer_req);

   assert_strobe_drops_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && xfer_valid) |=> !xfer_req);

   assert_connect_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (!err_flag && byte_ptr == '0 && mode12));

   assert_err_disconnect_R8: assert property (@(posedge clk) disable iff (!rst_n)
      chan_err_eor |-> (!busy && err_flag));

   assert_unit_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_load |=> $stable(addr_out[ADDR_W-1 -: LU_W]));

   assert_busy_alert_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (alert_addr && busy) |=> err_flag);

   assert_read_follows_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(xfer_valid && !xfer_write));

endmodule

bind hpt_disk_ctrl hpt_disk_ctrl_chk #(
   .LU_W   (LU_W),
   .ADDR_W (ADDR_W),
   .PTR_W  (PTR_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .alert_addr   (alert_addr),
   .addr_load    (addr_load),
   .xfer_valid   (xfer_valid),
   .xfer_write   (xfer_write),
   .busy         (busy),
   .xfer_req     (xfer_req),
   .err_flag     (err_flag),
   .chan_err_eor (chan_err_eor),
   .mode12       (mode12),
   .rd_valid     (rd_valid),
   .addr_out     (addr_out),
   .byte_ptr     (byte_ptr)
);

// File: tb/hpt_disk_ctrl_tb.sv
module hpt_disk_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int LU_W = 3, TRK_W = 2, SEC_W = 2, WPS_LOG2 = 2, CHAR_W = 12;
   localparam int STORE_WORDS = 384;
   localparam int ADDR_W = LU_W + TRK_W + SEC_W;
   localparam int PTR_W  = WPS_LOG2 + 1;
   localparam int NUM_LU = 1 << LU_W;

   // vector: start addr(7) stay(1) chars(5) expected addr(7) expected ptr(3)
   localparam int NVEC = 8;
   localparam logic [22:0] VEC [NVEC] = '{
      {7'h00, 1'b0, 5'd3,  7'h00, 3'd3},
      {7'h00, 1'b0, 5'd8,  7'h01, 3'd0},
      {7'h03, 1'b1, 5'd8,  7'h00, 3'd0},
      {7'h03, 1'b0, 5'd8,  7'h04, 3'd0},
      {7'h0F, 1'b0, 5'd8,  7'h00, 3'd0},
      {7'h1F, 1'b0, 5'd8,  7'h10, 3'd0},
      {7'h2B, 1'b1, 5'd10, 7'h28, 3'd2},
      {7'h5F, 1'b0, 5'd8,  7'h50, 3'd0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic conn_req = 0, alert_addr = 0, alert_stay = 0, addr_load = 0;
   logic [ADDR_W-1:0] addr_in = '0;
   logic [NUM_LU-1:0] wp_mask = '0;
   logic timer_tick = 0, xfer_valid = 0, xfer_write = 0;
   logic [CHAR_W-1:0] wr_char = '0;
   logic end_req = 0, end_write = 0;
   logic [1:0] sks_sel = 2'd0;
   logic sks_true, rd_valid, xfer_req, busy, err_flag, chan_err_eor, mode12;
   logic [CHAR_W-1:0] rd_char;
   logic [ADDR_W-1:0] addr_out;
   logic [PTR_W-1:0]  byte_ptr;

   int checks = 0, fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hpt_disk_ctrl #(
      .LU_W(LU_W), .TRK_W(TRK_W), .SEC_W(SEC_W), .WPS_LOG2(WPS_LOG2),
      .CHAR_W(CHAR_W), .STORE_WORDS(STORE_WORDS)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .conn_req(conn_req), .alert_addr(alert_addr),
      .alert_stay(alert_stay), .addr_load(addr_load), .addr_in(addr_in),
      .wp_mask(wp_mask), .timer_tick(timer_tick), .xfer_valid(xfer_valid),
      .xfer_write(xfer_write), .wr_char(wr_char), .end_req(end_req),
      .end_write(end_write), .sks_sel(sks_sel), .sks_true(sks_true),
      .rd_valid(rd_valid), .rd_char(rd_char), .xfer_req(xfer_req),
      .busy(busy), .err_flag(err_flag), .chan_err_eor(chan_err_eor),
      .mode12(mode12), .addr_out(addr_out), .byte_ptr(byte_ptr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic setup(input logic [ADDR_W-1:0] a, input logic stay);
      alert_addr = 1; alert_stay = stay;
      @(negedge clk); alert_addr = 0;
      addr_load = 1; addr_in = a;
      @(negedge clk); addr_load = 0;
      conn_req = 1;
      @(negedge clk); conn_req = 0;
   endtask

   task automatic xfer(input logic wr, input logic [CHAR_W-1:0] d);
      xfer_valid = 1; xfer_write = wr; wr_char = d;
      @(negedge clk); xfer_valid = 0; xfer_write = 0;
   endtask

   task automatic stop_op(input logic wr);
      end_req = 1; end_write = wr;
      @(negedge clk); end_req = 0; end_write = 0;
      for (int i = 0; i < 200 && busy; i++) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 addr", 32'(addr_out), 0);
      chk("R1 ptr", 32'(byte_ptr), 0);
      chk("R1 busy", 32'(busy), 0);
      chk("R1 err", 32'(err_flag), 0);
      chk("R1 req", 32'(xfer_req), 0);
      chk("R1 mode12", 32'(mode12), 0);
      sks_sel = 2'd0; #1 chk("R11 ready idle", 32'(sks_true), 1);
      sks_sel = 2'd1; #1 chk("R11 no error", 32'(sks_true), 1);
      sks_sel = 2'd3; #1 chk("R11 code 3", 32'(sks_true), 0);
      sks_sel = 2'd0;

      // vector table: address advance in both modes (R6, R7)
      for (int v = 0; v < NVEC; v++) begin
         setup(VEC[v][22:16], VEC[v][15]);
         for (int c = 0; c < int'(VEC[v][14:10]); c++) xfer(1'b0, '0);
         chk($sformatf("R6 R7 vec%0d addr", v), 32'(addr_out), 32'(VEC[v][9:3]));
         chk($sformatf("R6 vec%0d ptr", v), 32'(byte_ptr), 32'(VEC[v][2:0]));
         stop_op(1'b0);
      end

      // R4 request handshake
      setup(7'h02, 1'b0);
      chk("R3 busy after connect", 32'(busy), 1);
      chk("R3 mode12", 32'(mode12), 1);
      chk("R4 req after connect", 32'(xfer_req), 0);
      timer_tick = 1; @(negedge clk); timer_tick = 0;
      chk("R4 req after tick", 32'(xfer_req), 1);
      // fill sector 0x02 with nonzero data
      for (int c = 0; c < 8; c++) xfer(1'b1, 12'(12'h101 + c));
      chk("R4 req after strobe", 32'(xfer_req), 0);
      chk("R6 advance after write", 32'(addr_out), 32'h03);
      end_req = 1; end_write = 1; @(negedge clk); end_req = 0; end_write = 0;
      chk("R12 write ptr0 no fill", 32'(busy), 0);

      // R5 packing and R10 zero fill
      setup(7'h02, 1'b0);
      xfer(1'b1, 12'hABC); xfer(1'b1, 12'hDEF); xfer(1'b1, 12'h123);
      chk("R6 ptr 3", 32'(byte_ptr), 3);
      end_req = 1; end_write = 1; @(negedge clk); end_req = 0; end_write = 0;
      chk("R10 busy fill 1", 32'(busy), 1);
      @(negedge clk);
      chk("R10 busy fill 2", 32'(busy), 1);
      @(negedge clk);
      chk("R10 fill done", 32'(busy), 0);
      setup(7'h02, 1'b0);
      xfer(1'b0, '0);
      chk("R5 rd_valid", 32'(rd_valid), 1);
      chk("R5 even char", 32'(rd_char), 32'hABC);
      xfer(1'b0, '0); chk("R5 odd char", 32'(rd_char), 32'hDEF);
      xfer(1'b0, '0); chk("R5 even kept", 32'(rd_char), 32'h123);
      xfer(1'b0, '0); chk("R5 odd half cleared", 32'(rd_char), 32'h000);
      for (int c = 4; c < 8; c++) begin
         xfer(1'b0, '0);
         chk($sformatf("R10 zero word char%0d", c), 32'(rd_char), 0);
      end
      stop_op(1'b0);

      // R8 write protection
      setup(7'h12, 1'b0);
      xfer(1'b1, 12'h5A5);
      stop_op(1'b1);
      wp_mask = 8'b0000_0010;
      sks_sel = 2'd2; #1 chk("R11 protected unit", 32'(sks_true), 0);
      sks_sel = 2'd0;
      setup(7'h12, 1'b0);
      xfer(1'b1, 12'h777);
      chk("R8 err pulse", 32'(chan_err_eor), 1);
      chk("R8 err flag", 32'(err_flag), 1);
      chk("R8 disconnect", 32'(busy), 0);
      @(negedge clk);
      chk("R8 pulse one cycle", 32'(chan_err_eor), 0);
      sks_sel = 2'd1; #1 chk("R11 error latched", 32'(sks_true), 0);
      sks_sel = 2'd0;
      wp_mask = '0;
      setup(7'h12, 1'b0);
      chk("R3 connect clears err", 32'(err_flag), 0);
      xfer(1'b0, '0);
      chk("R8 data not stored", 32'(rd_char), 32'h5A5);
      stop_op(1'b0);

      // R9 past end of storage
      setup(7'h60, 1'b0);
      xfer(1'b0, '0);
      chk("R9 err pulse", 32'(chan_err_eor), 1);
      chk("R9 no read data", 32'(rd_valid), 0);
      chk("R9 disconnect", 32'(busy), 0);

      // R3 connect refused while load pending
      alert_addr = 1; alert_stay = 0; @(negedge clk); alert_addr = 0;
      conn_req = 1; @(negedge clk); conn_req = 0;
      chk("R3 refused when pending", 32'(busy), 0);
      addr_load = 1; addr_in = 7'h05; @(negedge clk); addr_load = 0;
      chk("R2 load", 32'(addr_out), 32'h05);
      conn_req = 1; @(negedge clk); conn_req = 0;
      chk("R3 accepted", 32'(busy), 1);
      sks_sel = 2'd0; #1 chk("R11 busy not ready", 32'(sks_true), 0);

      // R2 alert while busy
      alert_addr = 1; alert_stay = 1; @(negedge clk); alert_addr = 0;
      chk("R2 alert busy err", 32'(err_flag), 1);
      addr_load = 1; addr_in = 7'h33; @(negedge clk); addr_load = 0;
      chk("R2 load ignored", 32'(addr_out), 32'h05);
      xfer(1'b0, '0);
      end_req = 1; end_write = 0; @(negedge clk); end_req = 0;
      chk("R12 read end no fill", 32'(busy), 0);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule